// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block decides, for every memory access in a 32-bit address space, whether the access may proceed. It keeps eight programmable protection regions. Each region has an enable, a base address, a power-of-two size, separate permissions for privileged and unprivileged code, an execute-never flag, and an 8-bit mask. A set bit in the mask removes one eighth of the region from that region's coverage.

An access presents its address, its kind (read, write or execute) and its privilege level. The block answers in the same cycle. It drives allow or fault, a hit flag, and the number of the region that governed the decision. Where regions overlap, the highest-numbered matching region wins.

Two global controls are set through the same register path. The first switches the whole unit on. While the unit is off, every access passes. The second enables a background map, which lets privileged accesses that hit no region proceed. Region and control writes take effect from the cycle after the write.

Top module: `prot_region_unit`

## Requirements
- R1: While the unit enable is 0, every access is allowed, and acc_hit and acc_region are 0.
- R2: An enabled region of size S = 2^(N+1) bytes covers the addresses from B to B+S-1, where B is the programmed base with its low log2(S) bits ignored. A hit sets acc_hit and reports the index of the governing region on acc_region. On a miss, acc_region is 0.
- R3: A programmed size value N below 4 is stored as 4, giving a minimum region of 32 bytes. N = 31 covers the whole address space.
- R4: Bit k of a region's 8-bit subregion mask, when set, excludes the k-th eighth of the region, counted from the low address. An access there does not match that region, and may then match a lower-numbered region or no region.
- R5: When several enabled regions match, the highest-numbered one decides the outcome and is reported.
- R6: Each permission field is 2 bits: 00 none, 01 read-only, 10 read-write, 11 treated as none. Privileged accesses use the privileged field and unprivileged accesses use the unprivileged field. A read needs 01 or 10, and a write needs 10. acc_fault is always the inverse of acc_allow.
- R7: The access kind is encoded as 00 read, 01 write, 10 execute and 11 invalid. An execute is allowed only when a read would be allowed and the region's execute-never bit is 0. An invalid kind faults whenever the unit is enabled and a region matches.
- R8: With the unit enabled and no region matching, an unprivileged access faults. A privileged access is allowed for every kind only when the background map is enabled, and faults otherwise.
- R9: The check is combinational from the access inputs to the outputs. A region or control write changes results from the next cycle on, and leaves the result in the cycle of the write unchanged.
- R10: After reset, all regions, the unit enable and the background map are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Region register write strobe |
| cfg_idx | input | 3 | Region index to write |
| cfg_en | input | 1 | Region enable value |
| cfg_base | input | 32 | Region base address |
| cfg_size_n | input | 5 | Size exponent N, region is 2^(N+1) bytes |
| cfg_priv_perm | input | 2 | Privileged permission code |
| cfg_user_perm | input | 2 | Unprivileged permission code |
| cfg_xn | input | 1 | Execute-never flag |
| cfg_sub_off | input | 8 | Subregion disable mask |
| ctl_we | input | 1 | Global control write strobe |
| ctl_unit_en | input | 1 | Unit enable value |
| ctl_bg_en | input | 1 | Background map enable value |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | Access kind code |
| acc_priv | input | 1 | 1 for a privileged access |
| acc_allow | output | 1 | Access permitted |
| acc_fault | output | 1 | Access refused |
| acc_hit | output | 1 | A region governed the decision |
| acc_region | output | 3 | Index of the governing region |

## Verification
Directed accesses at one byte below, at, and one byte past each region edge show whether the alignment masking and the size clamp place the region boundaries correctly. Overlapping regions, with a subregion removed from the upper region, show whether priority and the fall-through to a lower region follow the rules. Accesses of each kind at both privilege levels, inside a region and outside every region, separate the two permission fields, the execute-never path and the background map. Random region layouts packed into one megabyte, together with random addresses near region bases, then exercise overlap and edge combinations that the directed cases miss.

// File: rtl/prot_pkg.sv
package prot_pkg;

    parameter int unsigned PR_ADDR_W  = 32;
    parameter int unsigned PR_REGIONS = 8;
    parameter int unsigned PR_SUBS    = 8;
    parameter int unsigned PR_SIZE_W  = 5;
    parameter int unsigned PR_MIN_N   = 4;

    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_RO   = 2'b01,
        PERM_RW   = 2'b10,
        PERM_RSVD = 2'b11
    } perm_e;

    typedef enum logic [1:0] {
        KIND_READ  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_EXEC  = 2'b10,
        KIND_BAD   = 2'b11
    } kind_e;

    typedef struct packed {
        logic                   en;
        logic [PR_ADDR_W-1:0]   base;
        logic [PR_SIZE_W-1:0]   size_n;
        perm_e                  priv_perm;
        perm_e                  user_perm;
        logic                   xn;
        logic [PR_SUBS-1:0]     sub_off;
    } region_cfg_t;

    typedef struct packed {
        logic unit_en;
        logic bg_en;
    } ctrl_t;

endpackage

// File: rtl/prot_region_file.sv
module prot_region_file
    import prot_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = PR_REGIONS,
    parameter int unsigned IDX_W       = $clog2(NUM_REGIONS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [IDX_W-1:0]              cfg_idx,
    input  region_cfg_t                   cfg_wdata,
    input  logic                          ctl_we,
    input  ctrl_t                         ctl_wdata,
    output region_cfg_t [NUM_REGIONS-1:0] regions_o,
    output ctrl_t                         ctrl_o
);

    localparam logic [PR_SIZE_W-1:0] MIN_N = PR_SIZE_W'(PR_MIN_N);

    typedef struct packed {
        region_cfg_t [NUM_REGIONS-1:0] rgn;
        ctrl_t                         ctl;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            state_d.rgn[cfg_idx] = cfg_wdata;
            if (cfg_wdata.size_n < MIN_N) begin
                state_d.rgn[cfg_idx].size_n = MIN_N;
            end
        end
        if (ctl_we) begin
            state_d.ctl = ctl_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign regions_o = state_q.rgn;
    assign ctrl_o    = state_q.ctl;

endmodule

// File: rtl/prot_region_match.sv
module prot_region_match
    import prot_pkg::*;
#(
    parameter int unsigned ADDR_W = PR_ADDR_W
) (
    input  region_cfg_t       cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam int unsigned SUB_IDX_W = $clog2(PR_SUBS);
    localparam int unsigned SHIFT_W   = PR_SIZE_W + 1;

    logic [SHIFT_W-1:0]   span_log;
    logic [ADDR_W-1:0]    keep_mask;
    logic                 in_range;
    logic [PR_SIZE_W-1:0] sub_shift;
    logic [ADDR_W-1:0]    sub_vec;
    logic [SUB_IDX_W-1:0] sub_idx;

    always_comb begin
        span_log  = SHIFT_W'(cfg.size_n) + SHIFT_W'(1);
        keep_mask = {ADDR_W{1'b1}} << span_log;
        in_range  = ((addr ^ cfg.base) & keep_mask) == '0;
        sub_shift = cfg.size_n + PR_SIZE_W'(1) - PR_SIZE_W'(SUB_IDX_W);
        sub_vec   = addr >> sub_shift;
        sub_idx   = sub_vec[SUB_IDX_W-1:0];
        hit       = cfg.en && in_range && !cfg.sub_off[sub_idx];
    end

endmodule

// File: rtl/prot_priority_sel.sv
module prot_priority_sel #(
    parameter int unsigned NUM_REGIONS = 8,
    parameter int unsigned IDX_W       = $clog2(NUM_REGIONS)
) (
    input  logic [NUM_REGIONS-1:0] hits,
    output logic                   any_hit,
    output logic [IDX_W-1:0]       win_idx
);

    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hits[i]) begin
                any_hit = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/prot_perm_eval.sv
module prot_perm_eval
    import prot_pkg::*;
(
    input  perm_e perm,
    input  logic  xn,
    input  kind_e kind,
    output logic  ok
);

    logic can_read;
    logic can_write;

    always_comb begin
        can_read  = (perm == PERM_RO) || (perm == PERM_RW);
        can_write = (perm == PERM_RW);
        unique case (kind)
            KIND_READ:  ok = can_read;
            KIND_WRITE: ok = can_write;
            KIND_EXEC:  ok = can_read && !xn;
            default:    ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/prot_region_unit.sv
module prot_region_unit
    import prot_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = PR_REGIONS,
    parameter int unsigned ADDR_W      = PR_ADDR_W,
    parameter int unsigned SIZE_W      = PR_SIZE_W,
    parameter int unsigned SUBS        = PR_SUBS,
    parameter int unsigned IDX_W       = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [SIZE_W-1:0] cfg_size_n,
    input  logic [1:0]        cfg_priv_perm,
    input  logic [1:0]        cfg_user_perm,
    input  logic              cfg_xn,
    input  logic [SUBS-1:0]   cfg_sub_off,
    input  logic              ctl_we,
    input  logic              ctl_unit_en,
    input  logic              ctl_bg_en,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic              acc_priv,
    output logic              acc_allow,
    output logic              acc_fault,
    output logic              acc_hit,
    output logic [IDX_W-1:0]  acc_region
);

    region_cfg_t                   wr_cfg;
    ctrl_t                         wr_ctl;
    region_cfg_t [NUM_REGIONS-1:0] regions;
    ctrl_t                         ctrl;
    logic [NUM_REGIONS-1:0]        hits;
    logic                          any_hit;
    logic [IDX_W-1:0]              win_idx;
    region_cfg_t                   win_cfg;
    perm_e                         eff_perm;
    logic                          perm_ok;

    always_comb begin
        wr_cfg.en        = cfg_en;
        wr_cfg.base      = cfg_base;
        wr_cfg.size_n    = cfg_size_n;
        wr_cfg.priv_perm = perm_e'(cfg_priv_perm);
        wr_cfg.user_perm = perm_e'(cfg_user_perm);
        wr_cfg.xn        = cfg_xn;
        wr_cfg.sub_off   = cfg_sub_off;
        wr_ctl.unit_en   = ctl_unit_en;
        wr_ctl.bg_en     = ctl_bg_en;
    end

    prot_region_file #(
        .NUM_REGIONS (NUM_REGIONS),
        .IDX_W       (IDX_W)
    ) i_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (wr_cfg),
        .ctl_we    (ctl_we),
        .ctl_wdata (wr_ctl),
        .regions_o (regions),
        .ctrl_o    (ctrl)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
        prot_region_match #(
            .ADDR_W (ADDR_W)
        ) i_match (
            .cfg  (regions[g]),
            .addr (acc_addr),
            .hit  (hits[g])
        );
    end

    prot_priority_sel #(
        .NUM_REGIONS (NUM_REGIONS),
        .IDX_W       (IDX_W)
    ) i_sel (
        .hits    (hits),
        .any_hit (any_hit),
        .win_idx (win_idx)
    );

    always_comb begin
        win_cfg  = regions[win_idx];
        eff_perm = acc_priv ? win_cfg.priv_perm : win_cfg.user_perm;
    end

    prot_perm_eval i_perm (
        .perm (eff_perm),
        .xn   (win_cfg.xn),
        .kind (kind_e'(acc_kind)),
        .ok   (perm_ok)
    );

    always_comb begin
        if (!ctrl.unit_en) begin
            acc_allow  = 1'b1;
            acc_hit    = 1'b0;
            acc_region = '0;
        end else if (any_hit) begin
            acc_allow  = perm_ok;
            acc_hit    = 1'b1;
            acc_region = win_idx;
        end else begin
            acc_allow  = acc_priv && ctrl.bg_en;
            acc_hit    = 1'b0;
            acc_region = '0;
        end
        acc_fault = !acc_allow;
    end

endmodule

// File: rtl/prot_region_unit_chk.sv
module prot_region_unit_chk #(
    parameter int unsigned IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we,
    input logic             ctl_unit_en,
    input logic             ctl_bg_en,
    input logic [1:0]       acc_kind,
    input logic             acc_priv,
    input logic             acc_allow,
    input logic             acc_fault,
    input logic             acc_hit,
    input logic [IDX_W-1:0] acc_region
);

    logic sh_unit;
    logic sh_bg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_unit <= 1'b0;
            sh_bg   <= 1'b0;
        end else if (ctl_we) begin
            sh_unit <= ctl_unit_en;
            sh_bg   <= ctl_bg_en;
        end
    end

    assert_disabled_allows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_unit |-> (acc_allow && !acc_hit));

    assert_region_zero_on_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_hit |-> (acc_region == '0));

    assert_allow_fault_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({acc_allow, acc_fault}));

    assert_bad_kind_faults_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_unit && acc_hit && acc_kind == 2'b11) |-> acc_fault);

    assert_user_miss_faults_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_unit && !acc_hit && !acc_priv) |-> acc_fault);

    assert_priv_miss_bg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_unit && !acc_hit && acc_priv) |-> (acc_allow == sh_bg));

    assert_ctl_next_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !ctl_unit_en) |=> acc_allow);

endmodule

bind prot_region_unit prot_region_unit_chk #(.IDX_W(IDX_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_we      (ctl_we),
    .ctl_unit_en (ctl_unit_en),
    .ctl_bg_en   (ctl_bg_en),
    .acc_kind    (acc_kind),
    .acc_priv    (acc_priv),
    .acc_allow   (acc_allow),
    .acc_fault   (acc_fault),
    .acc_hit     (acc_hit),
    .acc_region  (acc_region)
);

// File: tb/test_prot_region_unit.sv
module test_prot_region_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic        cfg_en = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [4:0]  cfg_size_n = '0;
    logic [1:0]  cfg_priv_perm = '0;
    logic [1:0]  cfg_user_perm = '0;
    logic        cfg_xn = 1'b0;
    logic [7:0]  cfg_sub_off = '0;
    logic        ctl_we = 1'b0;
    logic        ctl_unit_en = 1'b0;
    logic        ctl_bg_en = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        acc_priv = 1'b0;
    logic        acc_allow;
    logic        acc_fault;
    logic        acc_hit;
    logic [2:0]  acc_region;

    int checks = 0;
    int errors = 0;

    logic        m_en   [8];
    logic [31:0] m_base [8];
    int          m_n    [8];
    logic [1:0]  m_pp   [8];
    logic [1:0]  m_up   [8];
    logic        m_xn   [8];
    logic [7:0]  m_sub  [8];
    logic        m_unit;
    logic        m_bg;

    prot_region_unit i_prot_region_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_idx       (cfg_idx),
        .cfg_en        (cfg_en),
        .cfg_base      (cfg_base),
        .cfg_size_n    (cfg_size_n),
        .cfg_priv_perm (cfg_priv_perm),
        .cfg_user_perm (cfg_user_perm),
        .cfg_xn        (cfg_xn),
        .cfg_sub_off   (cfg_sub_off),
        .ctl_we        (ctl_we),
        .ctl_unit_en   (ctl_unit_en),
        .ctl_bg_en     (ctl_bg_en),
        .acc_addr      (acc_addr),
        .acc_kind      (acc_kind),
        .acc_priv      (acc_priv),
        .acc_allow     (acc_allow),
        .acc_fault     (acc_fault),
        .acc_hit       (acc_hit),
        .acc_region    (acc_region)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic perm_ok(input logic [1:0] perm, input logic xn,
                                     input logic [1:0] kind);
        logic rd;
        rd = (perm == 2'b01) || (perm == 2'b10);
        case (kind)
            2'b00:   return rd;
            2'b01:   return perm == 2'b10;
            2'b10:   return rd && !xn;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model(input logic [31:0] a, input logic [1:0] k, input logic p,
                         output logic allow, output logic hit, output logic [2:0] rgn);
        longint unsigned sz, lo, aa, eighth;
        hit = 1'b0;
        rgn = 3'd0;
        allow = 1'b1;
        if (!m_unit) return;
        aa = {32'd0, a};
        for (int i = 0; i < 8; i++) begin
            if (m_en[i]) begin
                sz = 64'd1 << (m_n[i] + 1);
                lo = {32'd0, m_base[i]} & ~(sz - 64'd1);
                if (aa >= lo && aa < lo + sz) begin
                    eighth = (aa - lo) / (sz / 64'd8);
                    if (!m_sub[i][eighth[2:0]]) begin
                        hit = 1'b1;
                        rgn = 3'(i);
                    end
                end
            end
        end
        if (hit) allow = perm_ok(p ? m_pp[rgn] : m_up[rgn], m_xn[rgn], k);
        else     allow = p && m_bg;
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    task automatic compare_now(input string tag);
        logic ea, eh;
        logic [2:0] er;
        model(acc_addr, acc_kind, acc_priv, ea, eh, er);
        check(tag, "allow", 32'(acc_allow), 32'(ea));
        check(tag, "fault", 32'(acc_fault), 32'(!ea));
        check(tag, "hit", 32'(acc_hit), 32'(eh));
        check(tag, "region", 32'(acc_region), 32'(er));
    endtask

    task automatic access(input logic [31:0] a, input logic [1:0] k, input logic p,
                          input string tag);
        @(negedge clk);
        acc_addr = a;
        acc_kind = k;
        acc_priv = p;
        #(CLK_PERIOD / 4);
        compare_now(tag);
    endtask

    task automatic set_region_inputs(input int idx, input logic en, input logic [31:0] base,
                                     input int n, input logic [1:0] pp, input logic [1:0] up,
                                     input logic xn, input logic [7:0] sub);
        cfg_idx = 3'(idx);
        cfg_en = en;
        cfg_base = base;
        cfg_size_n = 5'(n);
        cfg_priv_perm = pp;
        cfg_user_perm = up;
        cfg_xn = xn;
        cfg_sub_off = sub;
    endtask

    task automatic commit_region_model();
        m_en[cfg_idx] = cfg_en;
        m_base[cfg_idx] = cfg_base;
        m_n[cfg_idx] = (int'(cfg_size_n) < 4) ? 4 : int'(cfg_size_n);
        m_pp[cfg_idx] = cfg_priv_perm;
        m_up[cfg_idx] = cfg_user_perm;
        m_xn[cfg_idx] = cfg_xn;
        m_sub[cfg_idx] = cfg_sub_off;
    endtask

    task automatic wr_region(input int idx, input logic en, input logic [31:0] base,
                             input int n, input logic [1:0] pp, input logic [1:0] up,
                             input logic xn, input logic [7:0] sub);
        @(negedge clk);
        set_region_inputs(idx, en, base, n, pp, up, xn, sub);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        commit_region_model();
    endtask

    task automatic wr_ctl(input logic unit_en, input logic bg_en);
        @(negedge clk);
        ctl_unit_en = unit_en;
        ctl_bg_en = bg_en;
        ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
        m_unit = unit_en;
        m_bg = bg_en;
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 8; i++) begin
            m_en[i] = 1'b0; m_base[i] = '0; m_n[i] = 4;
            m_pp[i] = '0; m_up[i] = '0; m_xn[i] = 1'b0; m_sub[i] = '0;
        end
        m_unit = 1'b0;
        m_bg = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 and R1: after reset the unit is off, so everything passes
        access(32'h1234_5678, 2'b01, 1'b0, "R10");
        check("R10", "allow after reset", 32'(acc_allow), 32'd1);
        check("R1", "hit while disabled", 32'(acc_hit), 32'd0);

        // R8: unit on, no regions, no background map
        wr_ctl(1'b1, 1'b0);
        access(32'h0000_1000, 2'b00, 1'b1, "R8");
        check("R8", "priv miss without background", 32'(acc_fault), 32'd1);
        access(32'h0000_1000, 2'b00, 1'b0, "R8");
        wr_ctl(1'b1, 1'b1);
        for (int k = 0; k < 4; k++) begin
            access(32'h0000_1000, 2'(k), 1'b1, "R8");
            check("R8", "priv miss with background", 32'(acc_allow), 32'd1);
        end
        access(32'h0000_1000, 2'b00, 1'b0, "R8");
        check("R8", "user miss with background", 32'(acc_fault), 32'd1);

        // R2, R6: 4 KiB region, privileged RW, unprivileged RO
        wr_region(2, 1'b1, 32'h2000_0000, 11, 2'b10, 2'b01, 1'b0, 8'h00);
        access(32'h2000_0800, 2'b01, 1'b1, "R6");
        check("R2", "region index", 32'(acc_region), 32'd2);
        access(32'h2000_0800, 2'b01, 1'b0, "R6");
        check("R6", "user write to RO", 32'(acc_fault), 32'd1);
        access(32'h2000_0800, 2'b00, 1'b0, "R6");
        access(32'h2000_0FFF, 2'b00, 1'b0, "R2");
        access(32'h2000_1000, 2'b00, 1'b0, "R2");
        check("R2", "one past end", 32'(acc_hit), 32'd0);
        access(32'h1FFF_FFFF, 2'b00, 1'b0, "R2");

        // R2: unaligned base has its low bits ignored
        wr_region(2, 1'b1, 32'h2000_0123, 11, 2'b10, 2'b01, 1'b0, 8'h00);
        access(32'h2000_0000, 2'b00, 1'b0, "R2");
        check("R2", "aligned start hit", 32'(acc_hit), 32'd1);

        // R3: size 1 is clamped to 32 bytes; size 31 covers everything
        wr_region(0, 1'b1, 32'h0000_0100, 1, 2'b10, 2'b10, 1'b0, 8'h00);
        access(32'h0000_011F, 2'b01, 1'b0, "R3");
        check("R3", "last byte of 32B region", 32'(acc_hit), 32'd1);
        access(32'h0000_0120, 2'b01, 1'b0, "R3");
        wr_region(1, 1'b1, 32'h0000_0000, 31, 2'b01, 2'b00, 1'b1, 8'h00);
        access(32'hFFFF_FFFC, 2'b00, 1'b1, "R3");
        check("R3", "full map region", 32'(acc_region), 32'd1);
        wr_region(1, 1'b0, 32'h0000_0000, 31, 2'b01, 2'b00, 1'b1, 8'h00);

        // R4: subregion 2 of the 4 KiB region is switched off
        wr_region(2, 1'b1, 32'h2000_0000, 11, 2'b10, 2'b01, 1'b0, 8'b0000_0100);
        access(32'h2000_03FC, 2'b00, 1'b1, "R4");
        access(32'h2000_0400, 2'b00, 1'b0, "R4");
        check("R4", "disabled subregion", 32'(acc_hit), 32'd0);
        access(32'h2000_05FF, 2'b00, 1'b1, "R4");
        access(32'h2000_0600, 2'b00, 1'b0, "R4");

        // R5: a higher region overlaps; its removed subregion falls back to region 2
        wr_region(5, 1'b1, 32'h2000_0000, 15, 2'b00, 2'b00, 1'b0, 8'b0000_0001);
        access(32'h2000_2010, 2'b00, 1'b1, "R5");
        check("R5", "higher region wins", 32'(acc_region), 32'd5);
        access(32'h2000_0010, 2'b00, 1'b1, "R5");
        check("R5", "fall back to lower region", 32'(acc_region), 32'd2);

        // R7: execute-never and the invalid kind
        wr_region(6, 1'b1, 32'h4000_0000, 7, 2'b01, 2'b10, 1'b1, 8'h00);
        access(32'h4000_0040, 2'b10, 1'b1, "R7");
        check("R7", "exec with xn set", 32'(acc_fault), 32'd1);
        wr_region(6, 1'b1, 32'h4000_0000, 7, 2'b01, 2'b11, 1'b0, 8'h00);
        access(32'h4000_0040, 2'b10, 1'b1, "R7");
        check("R7", "exec on RO", 32'(acc_allow), 32'd1);
        access(32'h4000_0040, 2'b00, 1'b0, "R6");
        check("R6", "reserved code acts as none", 32'(acc_fault), 32'd1);
        access(32'h4000_0040, 2'b11, 1'b1, "R7");

        // R9: a write is not visible in its own cycle
        @(negedge clk);
        acc_addr = 32'h6000_0000;
        acc_kind = 2'b00;
        acc_priv = 1'b0;
        set_region_inputs(7, 1'b1, 32'h6000_0000, 9, 2'b10, 2'b10, 1'b0, 8'h00);
        cfg_we = 1'b1;
        #(CLK_PERIOD / 4);
        compare_now("R9");
        check("R9", "old result in write cycle", 32'(acc_hit), 32'd0);
        @(negedge clk);
        cfg_we = 1'b0;
        commit_region_model();
        #(CLK_PERIOD / 4);
        compare_now("R9");
        check("R9", "new result next cycle", 32'(acc_region), 32'd7);

        // random region layouts and accesses
        for (int it = 0; it < 4000; it++) begin
            if (it % 25 == 0) begin
                int n;
                n = ($urandom % 8 == 0) ? 4 + int'($urandom % 28) : int'($urandom % 14);
                wr_region(int'($urandom % 8), ($urandom % 4) != 0,
                          32'h2000_0000 | ($urandom & 32'h000F_FFFF), n,
                          2'($urandom), 2'($urandom), 1'($urandom), 8'($urandom));
            end
            if (it % 300 == 150) begin
                wr_ctl(($urandom % 6) != 0, 1'($urandom));
            end
            begin
                logic [31:0] a;
                int r;
                longint unsigned sz, lo, off;
                r = int'($urandom % 8);
                if ($urandom % 4 != 0) begin
                    sz = 64'd1 << (m_n[r] + 1);
                    lo = {32'd0, m_base[r]} & ~(sz - 64'd1);
                    off = {$urandom, $urandom} % (2 * sz);
                    a = 32'(lo + off);
                end else begin
                    a = $urandom;
                end
                access(a, 2'($urandom), 1'($urandom), "R5");
            end
        end

        // R1: switching the unit off lets a faulting access through
        wr_ctl(1'b0, 1'b0);
        access(32'h4000_0040, 2'b11, 1'b0, "R1");
        check("R1", "allow when unit off", 32'(acc_allow), 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule